// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and turns them into two processor inputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each source has a handler address and a 4-bit priority that software programs through a simple word-addressed register bus. Sources are enabled with write-one-to-set and disabled with write-one-to-clear. Software can raise any source itself through a soft-request register.

When the processor takes a normal interrupt, it reads the service register. That read returns the handler address of the winning source and opens a service level. While the level is open, requests of equal or lower urgency are masked. A write to the same register closes the innermost open level and restores the previous masking. Levels nest, so a more urgent source can pre-empt one already being serviced.

At most one source can be steered to the fast interrupt. That source bypasses prioritisation and is never presented as a normal interrupt.

Top module: `vic_top`

## Requirements
- R1: After a synchronous active-low reset, the enable, steering and soft-request masks are zero, every handler address and priority is zero, no level is open, and `irq_o` and `fiq_o` are low.
- R2: Writing the enable-set register (address 0x01) sets each enable bit whose data bit is 1 and leaves the others unchanged, so writing zero has no effect. Reading 0x01 returns the enable mask, with bit n for source n.
- R3: Writing the enable-clear register (address 0x02) clears each enable bit whose data bit is 1. Reading 0x02 also returns the enable mask.
- R4: Writing the soft-set register (address 0x04) raises a software request on each source whose data bit is 1. Writing the soft-clear register (address 0x05) removes it. Reading either address returns the soft mask. A source requests when (line OR soft request) AND enable.
- R5: The steering register (address 0x03) marks a source as fast when its bit is 1. A write with more than one bit set is ignored. `fiq_o` is the OR of the requests of marked sources, and a marked source never drives `irq_o`.
- R6: Address 0x40+n holds the 32-bit handler address of source n. Address 0x60+n holds its priority in data bits 3:0, and upper data bits are discarded. Both read back.
- R7: `irq_o` is high exactly when some requesting unmarked source has a priority value strictly below the current masking level. With no level open the masking level is 16, so every priority passes.
- R8: Reading the service register (address 0x06) returns the handler address of the winner: the lowest priority value, with ties going to the lowest source number. It returns 0 when there is no winner.
- R9: A read of 0x06 that finds a winner opens a level at the winner's priority. Afterwards only sources with strictly lower priority values can raise `irq_o`.
- R10: Any write to 0x06 closes the innermost open level and restores the previous masking level. With no level open, such a write has no effect.
- R11: Control addresses 0x00 and 0x07, and the range 0x20 to 0x3F, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines_i | input | 32 | Level-sensitive request lines, bit n for source n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 7 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read strobe |
| irq_o | output | 1 | Normal interrupt to the processor |
| fiq_o | output | 1 | Fast interrupt to the processor |

## Verification
Two functions can land on the same cycle: the service-register read that opens a level, and the arbitration it depends on. Arbitration sees a new request combination in the very cycle the read samples it. The bench provokes this by changing the request lines and reading the service register before any clock edge passes. It sweeps every single source and every pair of sources, and it judges each returned address against a winner computed from the programmed priorities and source numbers. The second collision is between the level a read opens and the request it masks. Nested reads and closing writes interleave with new requests, and `irq_o` is checked after each step.

// File: rtl/vic_pkg.sv
// Package: shared decode constants for the vectored interrupt controller.
// Assumes the upper two address bits select the register space.
package vic_pkg;

    // Control register selector, low three address bits in the control space.
    typedef enum logic [2:0] {
        CR_NONE   = 3'd0,
        CR_EN_SET = 3'd1,
        CR_EN_CLR = 3'd2,
        CR_FIQSEL = 3'd3,
        CR_SW_SET = 3'd4,
        CR_SW_CLR = 3'd5,
        CR_SVC    = 3'd6,
        CR_RSVD   = 3'd7
    } ctl_reg_e;

    // Register spaces, upper two address bits.
    localparam logic [1:0] SPACE_CTL = 2'b00;
    localparam logic [1:0] SPACE_VEC = 2'b10;
    localparam logic [1:0] SPACE_PRI = 2'b11;

endpackage

// File: rtl/vic_pri_arb.sv
// Module: priority arbiter. Picks the requesting source with the smallest
// priority value that is strictly below the masking level. Ties go to the
// lowest index. Purely combinational; the clock is used only by assertions.
module vic_pri_arb #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(NSRC),
    localparam int LVL_W = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_i,
    input  logic [PRIO_W-1:0] pri_i [NSRC],
    input  logic [LVL_W-1:0]  lvl_i,
    output logic              win_vld_o,
    output logic [IDX_W-1:0]  win_idx_o,
    output logic [PRIO_W-1:0] win_pri_o
);

    logic [LVL_W-1:0] best;

    // Linear scan; strict compare keeps the lowest index on a tie.
    always_comb begin
        best      = lvl_i;
        win_vld_o = 1'b0;
        win_idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && ({1'b0, pri_i[i]} < best)) begin
                best      = {1'b0, pri_i[i]};
                win_idx_o = IDX_W'(i);
                win_vld_o = 1'b1;
            end
        end
        win_pri_o = best[PRIO_W-1:0];
    end

    // R8: a reported winner is a requesting source.
    p_win_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> req_i[win_idx_o]);

    // R7: a reported winner passes the masking level.
    p_win_below_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> ({1'b0, win_pri_o} < lvl_i));

endmodule

// File: rtl/vic_lvl_stack.sv
// Module: stack of open service levels. A push records the priority of the
// source entering service; a pop restores the previous level. The output
// level is 2**PRIO_W when the stack is empty. Each push is assumed to be
// strictly below the current level, so the depth 2**PRIO_W never overflows.
module vic_lvl_stack #(
    parameter int PRIO_W = 4,
    localparam int DEPTH = 1 << PRIO_W,
    localparam int CNT_W = PRIO_W + 1,
    localparam int LVL_W = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_lvl_i,
    input  logic              pop_i,
    output logic [LVL_W-1:0]  lvl_o
);

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [PRIO_W-1:0] top_idx;

    assign top_idx = PRIO_W'(cnt - CNT_W'(1));

    // Occupancy counter: push has precedence, pop on empty is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push_i && (cnt < CNT_W'(DEPTH))) begin
            cnt <= cnt + CNT_W'(1);
        end else if (pop_i && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Storage: the pushed level lands in the first free slot.
    always_ff @(posedge clk) begin
        if (push_i && (cnt < CNT_W'(DEPTH))) begin
            mem[cnt[PRIO_W-1:0]] <= push_lvl_i;
        end
    end

    // Current masking level.
    assign lvl_o = (cnt == '0) ? LVL_W'(DEPTH) : {1'b0, mem[top_idx]};

    // R9: never push onto a full stack.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt < CNT_W'(DEPTH)));

    // R9: a new level is strictly more urgent than the current one.
    p_push_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> ({1'b0, push_lvl_i} < lvl_o));

    // R10: a pop on a non-empty stack removes exactly one level.
    p_pop_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && (cnt != '0)) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/vic_top.sv
// Module: vectored interrupt controller top. Holds the per-source register
// file, forms the effective requests, steers the single fast source, and
// drives the arbiter and the level stack. Assumes NSRC is at least 16 and
// no wider than the data bus. Reads are combinational; a read of the
// service register takes effect at the clock edge that ends it.
module vic_top
    import vic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(NSRC),
    localparam int ADDR_W = IDX_W + 2,
    localparam int LVL_W  = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_lines_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [NSRC-1:0]   en_q, fiq_q, sw_q;
    logic [DATA_W-1:0] vec_q [NSRC];
    logic [PRIO_W-1:0] pri_q [NSRC];

    logic [1:0]        space;
    logic [IDX_W-1:0]  idx;
    logic              ctl_hit;
    ctl_reg_e          ctl_sel;
    logic [NSRC-1:0]   wmask;

    logic [NSRC-1:0]   req, irq_req;
    logic              win_vld;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_pri;
    logic [LVL_W-1:0]  cur_lvl;
    logic              svc_push, svc_pop;

    // Address decode.
    assign space   = bus_addr_i[ADDR_W-1 -: 2];
    assign idx     = bus_addr_i[IDX_W-1:0];
    assign ctl_hit = (space == SPACE_CTL) && (idx[IDX_W-1:3] == '0);
    assign ctl_sel = ctl_reg_e'(idx[2:0]);
    assign wmask   = bus_wdata_i[NSRC-1:0];

    // Enable mask: write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (bus_wr_i && ctl_hit && (ctl_sel == CR_EN_SET)) begin
            en_q <= en_q | wmask;
        end else if (bus_wr_i && ctl_hit && (ctl_sel == CR_EN_CLR)) begin
            en_q <= en_q & ~wmask;
        end
    end

    // Fast-interrupt steering: writes with more than one bit set are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_q <= '0;
        end else if (bus_wr_i && ctl_hit && (ctl_sel == CR_FIQSEL)
                     && ($countones(wmask) <= 1)) begin
            fiq_q <= wmask;
        end
    end

    // Software request mask: set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (bus_wr_i && ctl_hit && (ctl_sel == CR_SW_SET)) begin
            sw_q <= sw_q | wmask;
        end else if (bus_wr_i && ctl_hit && (ctl_sel == CR_SW_CLR)) begin
            sw_q <= sw_q & ~wmask;
        end
    end

    // Per-source handler address and priority arrays.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (!rst_n) begin
                vec_q[i] <= '0;
                pri_q[i] <= '0;
            end else if (bus_wr_i && (idx == IDX_W'(i))) begin
                if (space == SPACE_VEC) vec_q[i] <= bus_wdata_i;
                if (space == SPACE_PRI) pri_q[i] <= bus_wdata_i[PRIO_W-1:0];
            end
        end
    end

    // Effective requests and steering.
    assign req     = (irq_lines_i | sw_q) & en_q;
    assign irq_req = req & ~fiq_q;
    assign fiq_o   = |(req & fiq_q);

    vic_pri_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (irq_req),
        .pri_i     (pri_q),
        .lvl_i     (cur_lvl),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx),
        .win_pri_o (win_pri)
    );

    // A service read opens a level; a service write closes one.
    assign svc_push = bus_rd_i && !bus_wr_i && ctl_hit && (ctl_sel == CR_SVC) && win_vld;
    assign svc_pop  = bus_wr_i && ctl_hit && (ctl_sel == CR_SVC);

    vic_lvl_stack #(.PRIO_W(PRIO_W)) stk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (svc_push),
        .push_lvl_i (win_pri),
        .pop_i      (svc_pop),
        .lvl_o      (cur_lvl)
    );

    assign irq_o = win_vld;

    // Read data multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        if (ctl_hit) begin
            unique case (ctl_sel)
                CR_EN_SET, CR_EN_CLR: bus_rdata_o = DATA_W'(en_q);
                CR_FIQSEL:            bus_rdata_o = DATA_W'(fiq_q);
                CR_SW_SET, CR_SW_CLR: bus_rdata_o = DATA_W'(sw_q);
                CR_SVC:               bus_rdata_o = win_vld ? vec_q[win_idx] : '0;
                default:              bus_rdata_o = '0;
            endcase
        end else if (space == SPACE_VEC) begin
            bus_rdata_o = vec_q[idx];
        end else if (space == SPACE_PRI) begin
            bus_rdata_o = DATA_W'(pri_q[idx]);
        end
    end

    // R5: at most one source is ever steered to the fast interrupt.
    p_one_fiq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fiq_q) <= 1);

    // R5: a steered source is never the normal-interrupt winner.
    p_fiq_not_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !fiq_q[win_idx]);

    // R9: after a level opens, the same request no longer passes the mask.
    p_self_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_push |=> (cur_lvl == {1'b0, $past(win_pri)}));

endmodule

// File: tb/vic_top_tb.sv
// Bench: sweeps single sources and all source pairs; expected winners are
// computed from the programmed priorities and source numbers.
module vic_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vic_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [31:0] vecv(int n);
        return 32'h8000_0000 ^ (32'(n) * 32'h0101_0104);
    endfunction

    function automatic logic [3:0] priv(int n);
        return 4'((n * 5) % 16);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Each bus task starts and ends at a falling edge.
    task automatic wrr(logic [6:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rdr(logic [6:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        #5 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        $display("FAIL watchdog actual hung expected finished");
        if (!done) $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] d, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fiq", 32'(fiq), 0);
        @(negedge clk);
        rdr(7'h01, d); chk("R1 enable", d, 0);
        rdr(7'h03, d); chk("R1 steer", d, 0);
        rdr(7'h04, d); chk("R1 soft", d, 0);
        rdr(7'h06, d); chk("R1 service", d, 0);
        rdr(7'h45, d); chk("R1 vector", d, 0);

        // R2 enable set, bit by bit
        exp = 0;
        for (int n = 0; n < 32; n++) begin
            wrr(7'h01, 32'h1 << n);
            exp |= 32'h1 << n;
            rdr(7'h01, d); chk("R2 set", d, exp);
        end
        wrr(7'h01, 0);
        rdr(7'h01, d); chk("R2 zero write", d, 32'hFFFF_FFFF);

        // R3 enable clear
        wrr(7'h02, 32'h5555_5555);
        rdr(7'h02, d); chk("R3 clear", d, 32'hAAAA_AAAA);
        wrr(7'h02, 0);
        rdr(7'h01, d); chk("R3 zero write", d, 32'hAAAA_AAAA);
        wrr(7'h01, 32'hFFFF_FFFF);

        // R6 handler addresses and priorities
        for (int n = 0; n < 32; n++) begin
            wrr(7'(8'h40 + n), vecv(n));
            wrr(7'(8'h60 + n), 32'hFFFF_FFF0 | 32'(priv(n)));
        end
        for (int n = 0; n < 32; n++) begin
            rdr(7'(8'h40 + n), d); chk("R6 vector", d, vecv(n));
            rdr(7'(8'h60 + n), d); chk("R6 priority", d, 32'(priv(n)));
        end

        // R11 unmapped reads
        rdr(7'h00, d); chk("R11 addr 00", d, 0);
        rdr(7'h07, d); chk("R11 addr 07", d, 0);
        rdr(7'h2A, d); chk("R11 addr 2A", d, 0);

        // R7 R8 R9 R10 each single source
        for (int n = 0; n < 32; n++) begin
            lines = 32'h1 << n;
            #1 chk("R7 single irq", 32'(irq), 1);
            rdr(7'h06, d); chk("R8 single vector", d, vecv(n));
            #1 chk("R9 self masked", 32'(irq), 0);
            wrr(7'h06, 0);
            #1 chk("R10 restored", 32'(irq), 1);
            lines = 0;
            #1 chk("R7 idle", 32'(irq), 0);
        end

        // R8 every pair: lower value wins, tie to lower number
        for (int a = 0; a < 32; a++) begin
            for (int b = a + 1; b < 32; b++) begin
                lines = (32'h1 << a) | (32'h1 << b);
                rdr(7'h06, d);
                chk("R8 pair", d, (priv(a) <= priv(b)) ? vecv(a) : vecv(b));
                wrr(7'h06, 0);
            end
        end
        lines = 0;

        // R9 R10 nesting: source 3 at 15, source 1 at 5
        lines = 32'h1 << 3;
        rdr(7'h06, d); chk("R9 outer vector", d, vecv(3));
        #1 chk("R9 outer masked", 32'(irq), 0);
        lines = (32'h1 << 3) | (32'h1 << 1);
        #1 chk("R9 preempt irq", 32'(irq), 1);
        rdr(7'h06, d); chk("R9 inner vector", d, vecv(1));
        #1 chk("R9 inner masked", 32'(irq), 0);
        wrr(7'h06, 0);
        #1 chk("R10 back to 15", 32'(irq), 1);
        rdr(7'h06, d); chk("R10 source 1 again", d, vecv(1));
        wrr(7'h06, 0);
        wrr(7'h06, 0);
        rdr(7'h06, d); chk("R10 all closed", d, vecv(1));
        wrr(7'h06, 0);
        lines = 0;

        // R10 close with nothing open
        wrr(7'h06, 0);
        lines = 32'h1 << 4;
        #1 chk("R10 empty pop irq", 32'(irq), 1);
        rdr(7'h06, d); chk("R10 empty pop vector", d, vecv(4));
        wrr(7'h06, 0);
        lines = 0;

        // R4 software requests and enable gating
        wrr(7'h04, 32'h1 << 7);
        rdr(7'h04, d); chk("R4 soft mask", d, 32'h80);
        #1 chk("R4 soft irq", 32'(irq), 1);
        rdr(7'h06, d); chk("R4 soft vector", d, vecv(7));
        wrr(7'h06, 0);
        wrr(7'h05, 32'h1 << 7);
        #1 chk("R4 soft cleared irq", 32'(irq), 0);
        rdr(7'h05, d); chk("R4 soft cleared mask", d, 0);
        wrr(7'h02, 32'h1 << 9);
        lines = 32'h1 << 9;
        #1 chk("R4 disabled line", 32'(irq), 0);
        wrr(7'h04, 32'h1 << 9);
        #1 chk("R4 disabled soft", 32'(irq), 0);
        wrr(7'h05, 32'h1 << 9);
        wrr(7'h01, 32'h1 << 9);
        #1 chk("R4 reenabled", 32'(irq), 1);
        lines = 0;

        // R5 fast steering
        wrr(7'h03, 32'h3);
        rdr(7'h03, d); chk("R5 two bits ignored", d, 0);
        wrr(7'h03, 32'h1 << 2);
        rdr(7'h03, d); chk("R5 one bit", d, 32'h4);
        lines = 32'h1 << 2;
        #1 chk("R5 fiq high", 32'(fiq), 1);
        chk("R5 no irq", 32'(irq), 0);
        lines = (32'h1 << 2) | (32'h1 << 6);
        rdr(7'h06, d); chk("R5 steered excluded", d, vecv(6));
        wrr(7'h06, 0);
        wrr(7'h02, 32'h1 << 2);
        #1 chk("R5 fiq disabled", 32'(fiq), 0);
        lines = 0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule